// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of an asynchronous byte-wide parallel flash bus. It takes one request at a time from a small valid/ready interface and turns it into the bus traffic the flash needs. That traffic is a series of unlock writes to two fixed addresses, then the command byte, and then either status polling or identification reads. Write-strobe width, read-strobe width and the recovery time between strobes are whole numbers of clock cycles, each set by a parameter.

The block recognises five operations: byte program, sector erase, chip erase, identification read and identification exit. After a program or erase it reads the target location repeatedly and checks bit 7 of the returned data. The operation counts as finished only when three reads in a row show the finished value. A per-operation cycle budget ends a poll that runs too long; in that case the block raises a timeout flag and issues no further bus cycles. An identification read returns the two code bytes on dedicated outputs.

Top module: `pflash_seq`

## Requirements
- R1: After reset, fl_ce_n, fl_oe_n and fl_we_n are 1, fl_dq_oe is 0, ready is 1, and done and err_timeout are 0.
- R2: req_op 0 (byte program) issues four writes as (address, data): (5555h, AAh), (2AAAh, 55h), (5555h, A0h), (req_addr, req_data). Unlock addresses drive 0 above bit 14.
- R3: req_op 1 (sector erase) issues six writes: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), then 30h at req_addr with bits 11..0 forced to 0.
- R4: req_op 2 (chip erase) issues the same first five writes as R3, and the sixth is 10h at 5555h.
- R5: req_op 3 (identification read) issues (5555h, AAh), (2AAAh, 55h), (5555h, 90h). It keeps the bus idle for at least IDA_CYC cycles after the last write's recovery, then reads address 0 into id_mfr and address 1 into id_dev before done.
- R6: req_op 4 (identification exit) issues (5555h, AAh), (2AAAh, 55h), (5555h, F0h) and makes no reads. done pulses REC_CYC+IDA_CYC cycles after the last write strobe rises.
- R7: fl_we_n stays low exactly WP_CYC cycles per write and stays high at least REC_CYC cycles between writes. fl_dq_oe is 1 only while fl_we_n is 0. fl_oe_n and fl_we_n are never 0 together, and fl_ce_n is 0 whenever either strobe is 0.
- R8: Every read holds fl_oe_n low for exactly RD_CYC cycles.
- R9: After a program or erase, the block reads req_addr until three successive reads match. A read matches when fl_dq_in bit 7 equals req_data bit 7 for a program, or equals 1 for an erase. A non-matching re-read restarts the count. done pulses for one cycle, REC_CYC cycles after the strobe of the last read rises.
- R10: The poll budget is TO_PROG_CYC, TO_SERASE_CYC or TO_CERASE_CYC, depending on the operation. If a read ends without confirmation once that many poll cycles have passed, err_timeout is set together with done and the bus stays idle. err_timeout clears when the next request is accepted.
- R11: A request is taken only while ready is 1. ready is 0 from the cycle after acceptance until done, and req_valid raised while ready is 0 adds no bus cycles.
- R12: req_op values 5, 6 and 7 are ignored: ready stays 1, no bus cycle starts and done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (0 program, 1 sector erase, 2 chip erase, 3 ID read, 4 ID exit) |
| req_addr | input | AW | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | Last operation ran out of poll budget |
| id_mfr | output | 8 | Manufacturer code from the last ID read |
| id_dev | output | 8 | Device code from the last ID read |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Write data toward the flash |
| fl_dq_oe | output | 1 | Data bus output enable |
| fl_dq_in | input | 8 | Read data from the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
Bus strobes change on the clock edge after the start of a cycle. The bench counts falling clock edges from each strobe transition and compares each strobe width with the exact WP_CYC or RD_CYC value. A poll completion must show done exactly REC_CYC cycles after the last read strobe rises. An ID exit must show done exactly REC_CYC+IDA_CYC cycles after the last write strobe rises, and the first ID read must not start before REC_CYC+IDA_CYC cycles have passed. All checks sample on the falling edge, half a cycle after the registers update, so every expected value is read in the cycle it becomes due.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  typedef enum logic [2:0] {
    OP_PROG   = 3'd0,
    OP_SERASE = 3'd1,
    OP_CERASE = 3'd2,
    OP_IDENT  = 3'd3,
    OP_IDQUIT = 3'd4
  } op_e;

  // number of bus writes that make up each command
  function automatic logic [2:0] step_total(op_e op);
    case (op)
      OP_PROG:              return 3'd4;
      OP_SERASE, OP_CERASE: return 3'd6;
      default:              return 3'd3;
    endcase
  endfunction

  // data byte written in a given step of a command
  function automatic logic [7:0] step_byte(op_e op, logic [2:0] step, logic [7:0] udata);
    case (step)
      3'd0, 3'd3: return (op == OP_PROG && step == 3'd3) ? udata : 8'hAA;
      3'd1, 3'd4: return 8'h55;
      3'd2: begin
        case (op)
          OP_PROG:   return 8'hA0;
          OP_IDENT:  return 8'h90;
          OP_IDQUIT: return 8'hF0;
          default:   return 8'h80;
        endcase
      end
      default: return (op == OP_SERASE) ? 8'h30 : 8'h10;
    endcase
  endfunction

endpackage

// File: rtl/pflash_seqgen.sv
module pflash_seqgen
  import pflash_pkg::*;
#(
  parameter int AW       = 19,
  parameter int SECT_LSB = 12
) (
  input  op_e             op,
  input  logic [2:0]      step,
  input  logic [AW-1:0]   tgt,
  input  logic [7:0]      udata,
  output logic [AW-1:0]   waddr,
  output logic [7:0]      wdata,
  output logic            last
);
  localparam logic [AW-1:0] ADDR_A = AW'(15'h5555);
  localparam logic [AW-1:0] ADDR_B = AW'(15'h2AAA);

  always_comb begin
    wdata = step_byte(op, step, udata);
    last  = (step == step_total(op) - 3'd1);
    case (step)
      3'd1, 3'd4: waddr = ADDR_B;
      3'd3:       waddr = (op == OP_PROG) ? tgt : ADDR_A;
      3'd5:       waddr = (op == OP_SERASE) ? {tgt[AW-1:SECT_LSB], {SECT_LSB{1'b0}}} : ADDR_A;
      default:    waddr = ADDR_A;
    endcase
  end
endmodule

// File: rtl/pflash_buscyc.sv
module pflash_buscyc #(
  parameter int AW      = 19,
  parameter int WP_CYC  = 10,
  parameter int RD_CYC  = 9,
  parameter int REC_CYC = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          is_wr,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          idle,
  output logic          fin,
  output logic [7:0]    rdata,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  localparam int CMAX = (WP_CYC > RD_CYC) ? ((WP_CYC > REC_CYC) ? WP_CYC : REC_CYC)
                                          : ((RD_CYC > REC_CYC) ? RD_CYC : REC_CYC);
  localparam int CW = $clog2(CMAX + 1);

  typedef enum logic [1:0] {B_IDLE, B_ACT, B_REC} bst_e;

  bst_e          st;
  logic [CW-1:0] cnt;
  logic          wr_q;

  assign idle = (st == B_IDLE);
  assign fin  = (st == B_REC) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= B_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      fl_addr   <= '0;
      fl_dq_out <= '0;
      fl_dq_oe  <= 1'b0;
      fl_ce_n   <= 1'b1;
      fl_oe_n   <= 1'b1;
      fl_we_n   <= 1'b1;
      rdata     <= '0;
    end else begin
      case (st)
        B_IDLE: if (start) begin
          st        <= B_ACT;
          fl_addr   <= addr;
          fl_dq_out <= wdata;
          wr_q      <= is_wr;
          fl_ce_n   <= 1'b0;
          if (is_wr) begin
            fl_we_n  <= 1'b0;
            fl_dq_oe <= 1'b1;
            cnt      <= CW'(WP_CYC - 1);
          end else begin
            fl_oe_n  <= 1'b0;
            cnt      <= CW'(RD_CYC - 1);
          end
        end
        B_ACT: begin
          if (cnt == '0) begin
            st       <= B_REC;
            cnt      <= CW'(REC_CYC - 1);
            fl_ce_n  <= 1'b1;
            fl_oe_n  <= 1'b1;
            fl_we_n  <= 1'b1;
            fl_dq_oe <= 1'b0;
            if (!wr_q) rdata <= fl_dq_in;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) st <= B_IDLE;
          else           cnt <= cnt - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pflash_seq.sv
module pflash_seq
  import pflash_pkg::*;
#(
  parameter int AW            = 19,
  parameter int WP_CYC        = 10,
  parameter int RD_CYC        = 9,
  parameter int REC_CYC       = 8,
  parameter int IDA_CYC       = 38,
  parameter int TO_PROG_CYC   = 5000,
  parameter int TO_SERASE_CYC = 6250000,
  parameter int TO_CERASE_CYC = 25000000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          ready,
  output logic          done,
  output logic          err_timeout,
  output logic [7:0]    id_mfr,
  output logic [7:0]    id_dev,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  localparam int TO_MAX = (TO_PROG_CYC > TO_SERASE_CYC)
                        ? ((TO_PROG_CYC > TO_CERASE_CYC) ? TO_PROG_CYC : TO_CERASE_CYC)
                        : ((TO_SERASE_CYC > TO_CERASE_CYC) ? TO_SERASE_CYC : TO_CERASE_CYC);
  localparam int TW = $clog2(TO_MAX + 1);
  localparam int IW = $clog2(IDA_CYC + 1);

  typedef enum logic [2:0] {T_IDLE, T_CMD, T_IDWAIT, T_IDRD, T_POLL} tst_e;

  tst_e          st;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [2:0]    step_q;
  logic [1:0]    ok_cnt;
  logic [TW-1:0] tmr;
  logic [TW-1:0] lim;
  logic [IW-1:0] wcnt;
  logic          id_sel;

  logic [AW-1:0] seq_addr, bus_addr;
  logic [7:0]    seq_data, bus_rdata;
  logic          seq_last, bus_idle, bus_fin, bus_start, exp7, hit;

  pflash_seqgen #(.AW(AW)) u_seqgen (
    .op(op_q), .step(step_q), .tgt(addr_q), .udata(data_q),
    .waddr(seq_addr), .wdata(seq_data), .last(seq_last)
  );

  assign bus_start = bus_idle && (st == T_CMD || st == T_IDRD || st == T_POLL);

  always_comb begin
    case (st)
      T_CMD:   bus_addr = seq_addr;
      T_IDRD:  bus_addr = AW'(id_sel);
      default: bus_addr = addr_q;
    endcase
    case (op_q)
      OP_SERASE: lim = TW'(TO_SERASE_CYC);
      OP_CERASE: lim = TW'(TO_CERASE_CYC);
      default:   lim = TW'(TO_PROG_CYC);
    endcase
  end

  pflash_buscyc #(.AW(AW), .WP_CYC(WP_CYC), .RD_CYC(RD_CYC), .REC_CYC(REC_CYC)) u_bus (
    .clk(clk), .rst(rst), .start(bus_start), .is_wr(st == T_CMD),
    .addr(bus_addr), .wdata(seq_data), .idle(bus_idle), .fin(bus_fin), .rdata(bus_rdata),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  assign exp7  = (op_q == OP_PROG) ? data_q[7] : 1'b1;
  assign hit   = (bus_rdata[7] == exp7);
  assign ready = (st == T_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= T_IDLE;
      op_q        <= OP_PROG;
      addr_q      <= '0;
      data_q      <= '0;
      step_q      <= '0;
      ok_cnt      <= '0;
      tmr         <= '0;
      wcnt        <= '0;
      id_sel      <= 1'b0;
      done        <= 1'b0;
      err_timeout <= 1'b0;
      id_mfr      <= '0;
      id_dev      <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        T_IDLE: if (req_valid && req_op <= 3'd4) begin
          st          <= T_CMD;
          op_q        <= op_e'(req_op);
          addr_q      <= req_addr;
          data_q      <= req_data;
          step_q      <= '0;
          err_timeout <= 1'b0;
        end
        T_CMD: if (bus_fin) begin
          if (seq_last) begin
            if (op_q == OP_IDENT || op_q == OP_IDQUIT) begin
              st   <= T_IDWAIT;
              wcnt <= IW'(IDA_CYC - 1);
            end else begin
              st     <= T_POLL;
              tmr    <= '0;
              ok_cnt <= '0;
            end
          end else begin
            step_q <= step_q + 3'd1;
          end
        end
        T_IDWAIT: begin
          if (wcnt == '0) begin
            if (op_q == OP_IDENT) begin
              st     <= T_IDRD;
              id_sel <= 1'b0;
            end else begin
              st   <= T_IDLE;
              done <= 1'b1;
            end
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        T_IDRD: if (bus_fin) begin
          if (!id_sel) begin
            id_mfr <= bus_rdata;
            id_sel <= 1'b1;
          end else begin
            id_dev <= bus_rdata;
            st     <= T_IDLE;
            done   <= 1'b1;
          end
        end
        T_POLL: begin
          if (tmr < lim) tmr <= tmr + 1'b1;
          if (bus_fin) begin
            if (hit && ok_cnt == 2'd2) begin
              st   <= T_IDLE;
              done <= 1'b1;
            end else begin
              ok_cnt <= hit ? ok_cnt + 2'd1 : 2'd0;
              if (tmr >= lim) begin
                st          <= T_IDLE;
                done        <= 1'b1;
                err_timeout <= 1'b1;
              end
            end
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pflash_seq_chk.sv
module pflash_seq_chk #(
  parameter int WP_CYC = 10,
  parameter int RD_CYC = 9
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic       ready,
  input logic       done,
  input logic       err_timeout,
  input logic       fl_dq_oe,
  input logic       fl_ce_n,
  input logic       fl_oe_n,
  input logic       fl_we_n
);
  logic [15:0] we_lo, oe_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_lo <= '0;
      oe_lo <= '0;
    end else begin
      we_lo <= fl_we_n ? 16'd0 : we_lo + 16'd1;
      oe_lo <= fl_oe_n ? 16'd0 : oe_lo + 16'd1;
    end
  end

  p_no_strobe_overlap_r7: assert property (@(posedge clk) disable iff (rst)
    !(!fl_oe_n && !fl_we_n));
  p_drive_only_in_write_r7: assert property (@(posedge clk) disable iff (rst)
    fl_dq_oe |-> !fl_we_n);
  p_chip_selected_r7: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);
  p_write_width_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> (we_lo == 16'(WP_CYC)));
  p_read_width_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_oe_n) |-> (oe_lo == 16'(RD_CYC)));
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_err_with_done_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(err_timeout) |-> done);
  p_quiet_when_ready_r11: assert property (@(posedge clk) disable iff (rst)
    ready |-> (fl_ce_n && fl_we_n && fl_oe_n));
  p_accept_leaves_ready_r11: assert property (@(posedge clk) disable iff (rst)
    (ready && req_valid && req_op <= 3'd4) |=> !ready);
  p_bad_op_ignored_r12: assert property (@(posedge clk) disable iff (rst)
    (ready && req_valid && req_op > 3'd4) |=> ready);
endmodule

bind pflash_seq pflash_seq_chk #(.WP_CYC(WP_CYC), .RD_CYC(RD_CYC)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .ready(ready),
  .done(done), .err_timeout(err_timeout), .fl_dq_oe(fl_dq_oe), .fl_ce_n(fl_ce_n),
  .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
);

// File: tb/tb_pflash_seq.sv
`timescale 1ns/1ps
module tb_pflash_seq;
  localparam int AW   = 19;
  localparam int WP   = 10;
  localparam int RD   = 9;
  localparam int REC  = 8;
  localparam int IDA  = 40;
  localparam int TOP  = 300;
  localparam int TOSE = 600;
  localparam int TOCE = 900;
  localparam logic [7:0] MFR_CODE = 8'h3C;
  localparam logic [7:0] DEV_CODE = 8'h7E;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          ready, done, err_timeout, fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;
  logic [7:0]    id_mfr, id_dev, fl_dq_out, fl_dq_in;
  logic [AW-1:0] fl_addr;

  always #2 clk = ~clk;

  pflash_seq #(.AW(AW), .WP_CYC(WP), .RD_CYC(RD), .REC_CYC(REC), .IDA_CYC(IDA),
               .TO_PROG_CYC(TOP), .TO_SERASE_CYC(TOSE), .TO_CERASE_CYC(TOCE)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .ready(ready), .done(done), .err_timeout(err_timeout),
    .id_mfr(id_mfr), .id_dev(id_dev), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
    .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
    .fl_we_n(fl_we_n)
  );

  int vectors = 0;
  int miscmp  = 0;

  // behavioural flash: each read strobe takes the next good/bad flag
  bit         ok_q[$];
  bit         dflt_ok  = 1'b1;
  bit         cur_ok   = 1'b1;
  bit         id_mode  = 1'b0;
  bit         er_mode  = 1'b0;
  logic [7:0] prog_val = '0;

  always_comb begin
    if (id_mode)      fl_dq_in = (fl_addr == '0) ? MFR_CODE : (fl_addr == AW'(1)) ? DEV_CODE : 8'h00;
    else if (er_mode) fl_dq_in = cur_ok ? 8'hFF : 8'h00;
    else              fl_dq_in = cur_ok ? prog_val : (prog_val ^ 8'h80);
  end

  logic [AW-1:0] got_a[$], exp_a[$], rd_a[$];
  logic [7:0]    got_d[$], exp_d[$];
  bit pw, po, done_seen, err_seen;
  int lo_w, hi_w, lo_o, we_since, oe_since, d_we, d_oe, ce_act, first_gap;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscmp++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // per-clock bus monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      pw = 1; po = 1; hi_w = 1000; lo_w = 0; lo_o = 0; we_since = 0; oe_since = 0; ce_act = 0;
    end else begin
      chk(!(!fl_oe_n && !fl_we_n), "R7 strobe overlap", {fl_oe_n, fl_we_n}, 2'b11);
      chk(!(fl_dq_oe && fl_we_n), "R7 data drive outside write", fl_dq_oe, 0);
      if (!fl_we_n || !fl_oe_n) chk(!fl_ce_n, "R7 chip enable with strobe", fl_ce_n, 0);
      if (!fl_we_n && pw) begin
        got_a.push_back(fl_addr); got_d.push_back(fl_dq_out);
        chk(hi_w >= REC, "R7 write recovery", hi_w, REC);
        lo_w = 1;
      end else if (!fl_we_n) lo_w++;
      if (fl_we_n && !pw) begin
        chk(lo_w == WP, "R7 write width", lo_w, WP);
        hi_w = 1; we_since = 0;
      end else if (fl_we_n) begin hi_w++; we_since++; end
      if (!fl_oe_n && po) begin
        if (ok_q.size() > 0) cur_ok = ok_q.pop_front(); else cur_ok = dflt_ok;
        if (rd_a.size() == 0) first_gap = we_since;
        rd_a.push_back(fl_addr);
        lo_o = 1;
      end else if (!fl_oe_n) lo_o++;
      if (fl_oe_n && !po) begin
        chk(lo_o == RD, "R8 read width", lo_o, RD);
        oe_since = 0;
      end else if (fl_oe_n) oe_since++;
      if (!fl_ce_n) ce_act++;
      if (done) begin done_seen = 1; err_seen = err_timeout; d_we = we_since; d_oe = oe_since; end
      pw = fl_we_n; po = fl_oe_n;
    end
  end

  task automatic build_exp(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d);
    logic [AW-1:0] ua = AW'(15'h5555);
    logic [AW-1:0] ub = AW'(15'h2AAA);
    exp_a.delete(); exp_d.delete();
    exp_a.push_back(ua); exp_d.push_back(8'hAA);
    exp_a.push_back(ub); exp_d.push_back(8'h55);
    exp_a.push_back(ua);
    case (op)
      3'd0: begin exp_d.push_back(8'hA0); exp_a.push_back(a); exp_d.push_back(d); end
      3'd3: exp_d.push_back(8'h90);
      3'd4: exp_d.push_back(8'hF0);
      default: begin
        exp_d.push_back(8'h80);
        exp_a.push_back(ua); exp_d.push_back(8'hAA);
        exp_a.push_back(ub); exp_d.push_back(8'h55);
        if (op == 3'd1) begin exp_a.push_back({a[AW-1:12], 12'h000}); exp_d.push_back(8'h30); end
        else            begin exp_a.push_back(ua); exp_d.push_back(8'h10); end
      end
    endcase
  endtask

  task automatic cmp_writes(input string tag);
    chk(got_a.size() == exp_a.size(), {tag, " write count"}, got_a.size(), exp_a.size());
    for (int i = 0; i < exp_a.size() && i < got_a.size(); i++) begin
      chk(got_a[i] == exp_a[i], {tag, " write address"}, got_a[i], exp_a[i]);
      chk(got_d[i] == exp_d[i], {tag, " write data"}, got_d[i], exp_d[i]);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d);
    got_a.delete(); got_d.delete(); rd_a.delete();
    done_seen = 0; err_seen = 0;
    build_exp(op, a, d);
    @(negedge clk);
    chk(ready === 1'b1, "R11 ready before request", ready, 1);
    req_valid = 1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done(input int maxc, input string tag);
    int n = 0;
    while (!done_seen && n < maxc) begin @(posedge clk); n++; end
    @(negedge clk);
    chk(done_seen, {tag, " done seen"}, done_seen, 1);
  endtask

  // first index where three successive reads are good, plus three
  function automatic int reads_needed(input bit pat[$]);
    for (int i = 0; i + 2 < pat.size(); i++)
      if (pat[i] && pat[i+1] && pat[i+2]) return i + 3;
    return -1;
  endfunction

  task automatic poll_case(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                           input bit pat[$], input string tag);
    int exp_rd = reads_needed(pat);
    ok_q = pat; dflt_ok = 1; prog_val = d; er_mode = (op != 3'd0);
    do_op(op, a, d);
    wait_done(4000, tag);
    cmp_writes(tag);
    chk(rd_a.size() == exp_rd, "R9 poll read count", rd_a.size(), exp_rd);
    foreach (rd_a[i]) chk(rd_a[i] == a, "R9 poll address", rd_a[i], a);
    chk(!err_seen, "R10 no timeout within budget", err_seen, 0);
    chk(d_oe == REC, "R9 done latency after last read", d_oe, REC);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscmp++;
    $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    int snap;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(ready == 1 && done == 0 && err_timeout == 0, "R1 reset status", {ready, done, err_timeout}, 3'b100);
    chk(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe, "R1 reset bus", {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe}, 4'b1110);

    // R2 program, busy for two reads, plus a request while busy (R11)
    ok_q = '{0, 0, 1, 1, 1}; dflt_ok = 1; prog_val = 8'h5A; er_mode = 0;
    do_op(3'd0, 19'h4_1234, 8'h5A);
    repeat (20) @(negedge clk);
    chk(ready == 0, "R11 busy after accept", ready, 0);
    req_valid = 1; req_op = 3'd2; @(negedge clk); req_valid = 0;
    wait_done(4000, "R2");
    cmp_writes("R2 program");
    chk(rd_a.size() == 5, "R9 poll read count", rd_a.size(), 5);
    snap = ce_act;
    repeat (60) @(negedge clk);
    chk(ce_act == snap, "R11 no cycles from busy request", ce_act, snap);
    chk(ready == 1, "R11 ready after done", ready, 1);

    // R9 false completion rejected, bit 7 clear in target byte
    poll_case(3'd0, 19'h0_0F0F, 8'h33, '{1, 0, 1, 1, 1}, "R9 reject glitch");
    poll_case(3'd0, 19'h7_FFFF, 8'hC4, '{1, 1, 0, 1, 1, 1}, "R9 late glitch");
    // R3 sector erase, R4 chip erase
    poll_case(3'd1, 19'h2_3ABC, 8'h00, '{0, 0, 0, 1, 1, 1}, "R3 sector erase");
    poll_case(3'd2, 19'h1_2345, 8'h00, '{0, 0, 1, 1, 1}, "R4 chip erase");

    // R5 ID read
    id_mode = 1;
    do_op(3'd3, 19'h5_5555, 8'h00);
    wait_done(4000, "R5");
    cmp_writes("R5 id entry");
    chk(rd_a.size() == 2, "R5 id read count", rd_a.size(), 2);
    if (rd_a.size() == 2) begin
      chk(rd_a[0] == '0, "R5 first id address", rd_a[0], 0);
      chk(rd_a[1] == AW'(1), "R5 second id address", rd_a[1], 1);
    end
    chk(first_gap >= REC + IDA, "R5 access wait", first_gap, REC + IDA);
    chk(id_mfr == MFR_CODE, "R5 manufacturer code", id_mfr, MFR_CODE);
    chk(id_dev == DEV_CODE, "R5 device code", id_dev, DEV_CODE);
    id_mode = 0;

    // R6 ID exit
    do_op(3'd4, 19'h0_1111, 8'h00);
    wait_done(4000, "R6");
    cmp_writes("R6 id exit");
    chk(rd_a.size() == 0, "R6 no reads", rd_a.size(), 0);
    chk(d_we == REC + IDA, "R6 done latency", d_we, REC + IDA);

    // R10 timeout on a program that never completes
    ok_q.delete(); dflt_ok = 0; prog_val = 8'h81; er_mode = 0;
    do_op(3'd0, 19'h3_0003, 8'h81);
    wait_done(4000, "R10");
    chk(err_seen == 1, "R10 timeout flagged", err_seen, 1);
    chk(rd_a.size() >= TOP / (RD + REC + 1), "R10 polled until budget", rd_a.size(), TOP / (RD + REC + 1));
    snap = ce_act;
    repeat (80) @(negedge clk);
    chk(ce_act == snap, "R10 bus idle after timeout", ce_act, snap);
    chk(err_timeout == 1, "R10 flag held", err_timeout, 1);
    dflt_ok = 1;
    poll_case(3'd1, 19'h6_0000, 8'h00, '{1, 1, 1}, "R10 clear on next");
    chk(err_timeout == 0, "R10 flag cleared", err_timeout, 0);

    // R12 reserved op codes
    for (int k = 5; k < 8; k++) begin
      done_seen = 0;
      snap = ce_act;
      @(negedge clk);
      req_valid = 1; req_op = 3'(k); @(negedge clk); req_valid = 0;
      repeat (60) @(negedge clk);
      chk(ce_act == snap && !done_seen && ready, "R12 reserved op ignored", ce_act, snap);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule